// File: doc/BRIEF.md
# Runtime-Configurable Cache Tag Model

This block decides, for a stream of memory references from several simulated cores, whether each reference hits or misses in that core's private cache. It also decides whether the line it displaces must be written back. It keeps only per-line metadata: a tag, a valid bit and a dirty bit for every way, plus one replacement pointer per set. It never holds line contents, so large target caches cost little storage. Each core owns a separate copy of the metadata, chosen by the core number that comes with the request.

The geometry can be reprogrammed without rebuilding the hardware. Three control fields set the line size, the number of sets and the number of ways. Each field is clamped to limits fixed by parameters. The storage is sized for the largest geometry. At runtime the address is shifted right by the programmed line size, and the low bits of the result are masked to the programmed set count to form the set index. The remaining upper bits form the tag. All enabled ways of the selected set are compared in the same cycle.

After a geometry change, a flush pulse is needed to invalidate every line. Downstream logic counts the hit, miss and writeback pulses and turns them into latency.

Top module: `tagsim_cache_model`

## Requirements
- R1: After reset the geometry outputs read line log2 = 7 (128-byte lines), set bits = 6 (64 sets) and ways = 4. `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_wb` are 0, and every line is invalid, so the first lookup misses.
- R2: A control write with `cfg_wr` high updates one field, chosen by `cfg_sel`:
  - `cfg_sel` = 0 selects line log2, clamped into [MIN_LINE_LOG2, MAX_LINE_LOG2].
  - `cfg_sel` = 1 selects set bits, clamped to at most MAX_SET_BITS.
  - `cfg_sel` = 2 selects the way count, clamped into [1, MAX_WAYS].
  - `cfg_sel` = 3 changes nothing.
  
  The new value appears on the geometry outputs one cycle after the write.
- R3: A request presented with `req_valid` high is answered one clock later. `rsp_valid` is 1 for exactly that cycle, and exactly one of `rsp_hit` and `rsp_miss` is 1. Without a request, all response flags are 0.
- R4: The set index is (addr >> line_log2) modulo 2^set_bits, and the tag is (addr >> line_log2) >> set_bits. Two addresses in the same line hit each other; the next line is a separate entry.
- R5: Up to the programmed number of lines that map to one set are held at once, and every one of them hits.
- R6: On a miss, the way to fill is taken from a per-set round-robin pointer. The pointer starts at way 0 and wraps back to 0 after the last programmed way.
- R7: Ways at or above the programmed way count never hit and are never filled.
- R8: Dirty state and writebacks follow these rules:
  - A write hit or a write miss marks the line dirty.
  - A miss that displaces a valid dirty line raises `rsp_wb`, and `rsp_victim_line` carries that line's address (the byte address >> line_log2).
  - A clean or invalid victim gives `rsp_wb` = 0 and `rsp_victim_line` = 0.
- R9: A flush pulse clears all valid bits, dirty bits and replacement pointers. A request presented in the flush cycle is dropped, so `rsp_valid` is 0 in the following cycle.
- R10: Each core's metadata is private. The same address from another core misses on its own, and another core's fills and evictions do not disturb this core's lines.
- R11: After reprogramming the line size and set count, followed by a flush, hits, set conflicts and victim line addresses all follow the new geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control field write strobe |
| cfg_sel | input | 2 | Field select: 0 line log2, 1 set bits, 2 ways, 3 none |
| cfg_wdata | input | 8 | Value to write, clamped on entry |
| flush | input | 1 | Invalidate all metadata of every core |
| req_valid | input | 1 | Lookup request strobe |
| req_core | input | $clog2(NUM_CORES) | Core whose private metadata is used |
| req_addr | input | ADDR_W | Byte address of the reference |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Reference hit |
| rsp_miss | output | 1 | Reference missed and was allocated |
| rsp_wb | output | 1 | Displaced line was dirty and must be written back |
| rsp_victim_line | output | ADDR_W-MIN_LINE_LOG2 | Line address of the written-back victim, else 0 |
| geo_line_log2 | output | 5 | Current line size, log2 bytes |
| geo_set_bits | output | 5 | Current set count, log2 |
| geo_ways | output | 5 | Current number of enabled ways |

## Verification
The bench builds the block with its defaults: two cores, 32-bit addresses, up to 64 sets of 4 ways, and lines from 16 to 128 bytes. At this size the full 32 KB, 4-way, 128-byte geometry and a wrap of the round-robin pointer within a single set are both reachable. So are clamping at both ends of every field and a cross-core isolation case. A 2-way setting and a 32-byte, 4-set setting bring the disabled-way path into play, along with victim line addresses rebuilt under a narrow index.

// File: rtl/tagsim_pkg.sv
package tagsim_pkg;

    // Width of each geometry field as seen on the ports.
    localparam int FIELD_W = 5;

    typedef enum logic [1:0] {
        SEL_LINE = 2'd0,
        SEL_SETS = 2'd1,
        SEL_WAYS = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [FIELD_W-1:0] line_log2;
        logic [FIELD_W-1:0] set_bits;
        logic [FIELD_W-1:0] ways;
    } geom_t;

    // Bound a raw control value into [lo, hi].
    function automatic logic [FIELD_W-1:0] clamp_field(input logic [7:0] v,
                                                       input int lo,
                                                       input int hi);
        int t;
        t = int'(v);
        if (t < lo) t = lo;
        if (t > hi) t = hi;
        return FIELD_W'(t);
    endfunction

endpackage

// File: rtl/tagsim_cfg.sv
module tagsim_cfg
    import tagsim_pkg::*;
#(
    parameter int MIN_LINE_LOG2 = 4,
    parameter int MAX_LINE_LOG2 = 7,
    parameter int MAX_SET_BITS  = 6,
    parameter int MAX_WAYS      = 4,
    parameter int DEF_LINE_LOG2 = 7,
    parameter int DEF_SET_BITS  = 6,
    parameter int DEF_WAYS      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    output geom_t      geom
);

    always_ff @(posedge clk) begin
        if (rst) begin
            geom.line_log2 <= FIELD_W'(DEF_LINE_LOG2);
            geom.set_bits  <= FIELD_W'(DEF_SET_BITS);
            geom.ways      <= FIELD_W'(DEF_WAYS);
        end else if (wr) begin
            case (cfg_sel_e'(sel))
                SEL_LINE: geom.line_log2 <= clamp_field(wdata, MIN_LINE_LOG2, MAX_LINE_LOG2);
                SEL_SETS: geom.set_bits  <= clamp_field(wdata, 0, MAX_SET_BITS);
                SEL_WAYS: geom.ways      <= clamp_field(wdata, 1, MAX_WAYS);
                default: ;
            endcase
        end
    end

    // R2: the way count stays inside its legal range
    p_ways_range_r2: assert property (@(posedge clk) disable iff (rst)
        (geom.ways != '0) && (int'(geom.ways) <= MAX_WAYS));

    // R2: the line size stays inside its legal range
    p_line_range_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(geom.line_log2) >= MIN_LINE_LOG2) && (int'(geom.line_log2) <= MAX_LINE_LOG2));

    // R2: the unused select leaves the geometry alone
    p_sel_none_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && (sel == 2'd3)) |=> $stable(geom));

endmodule

// File: rtl/tagsim_match.sv
module tagsim_match
    import tagsim_pkg::*;
#(
    parameter int TAG_W    = 28,
    parameter int MAX_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic [MAX_WAYS-1:0]            valid,
    input  logic [MAX_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]               key,
    input  logic [FIELD_W-1:0]             ways,
    output logic [MAX_WAYS-1:0]            hit_vec,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way
);

    // One comparator per way, all evaluated together.
    for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
        assign hit_vec[w] = valid[w] && (FIELD_W'(w) < ways) && (tags[w] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < MAX_WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tagsim_victim.sv
module tagsim_victim
    import tagsim_pkg::*;
#(
    parameter int WAY_W = 2
) (
    input  logic [WAY_W-1:0]   ptr,
    input  logic [FIELD_W-1:0] ways,
    output logic [WAY_W-1:0]   victim,
    output logic [WAY_W-1:0]   next_ptr
);

    // A pointer left beyond a shrunken way count restarts at way 0.
    always_comb begin
        victim = (FIELD_W'(ptr) >= ways) ? '0 : ptr;
        if ((FIELD_W'(victim) + FIELD_W'(1)) >= ways) next_ptr = '0;
        else                                          next_ptr = victim + WAY_W'(1);
    end

endmodule

// File: rtl/tagsim_cache_model.sv
module tagsim_cache_model
    import tagsim_pkg::*;
#(
    parameter int NUM_CORES     = 2,
    parameter int ADDR_W        = 32,
    parameter int MIN_LINE_LOG2 = 4,
    parameter int MAX_LINE_LOG2 = 7,
    parameter int MAX_SET_BITS  = 6,
    parameter int MAX_WAYS      = 4,
    parameter int DEF_LINE_LOG2 = 7,
    parameter int DEF_SET_BITS  = 6,
    parameter int DEF_WAYS      = 4,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int LINE_W = ADDR_W - MIN_LINE_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    input  logic               flush,
    input  logic               req_valid,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_wb,
    output logic [LINE_W-1:0]  rsp_victim_line,
    output logic [FIELD_W-1:0] geo_line_log2,
    output logic [FIELD_W-1:0] geo_set_bits,
    output logic [FIELD_W-1:0] geo_ways
);

    localparam int WAY_W = $clog2(MAX_WAYS);
    localparam int NSETS = 1 << MAX_SET_BITS;
    localparam int TAG_W = LINE_W;

    // ---------------- geometry registers ----------------
    geom_t geom;

    tagsim_cfg #(
        .MIN_LINE_LOG2 (MIN_LINE_LOG2),
        .MAX_LINE_LOG2 (MAX_LINE_LOG2),
        .MAX_SET_BITS  (MAX_SET_BITS),
        .MAX_WAYS      (MAX_WAYS),
        .DEF_LINE_LOG2 (DEF_LINE_LOG2),
        .DEF_SET_BITS  (DEF_SET_BITS),
        .DEF_WAYS      (DEF_WAYS)
    ) cfg_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .geom  (geom)
    );

    assign geo_line_log2 = geom.line_log2;
    assign geo_set_bits  = geom.set_bits;
    assign geo_ways      = geom.ways;

    // ---------------- metadata storage ----------------
    logic [MAX_WAYS-1:0][TAG_W-1:0] tag_q   [NUM_CORES][NSETS];
    logic [MAX_WAYS-1:0]            valid_q [NUM_CORES][NSETS];
    logic [MAX_WAYS-1:0]            dirty_q [NUM_CORES][NSETS];
    logic [WAY_W-1:0]               rr_q    [NUM_CORES][NSETS];

    // ---------------- address split ----------------
    logic [LINE_W-1:0]       line_a;
    logic [MAX_SET_BITS-1:0] set_mask;
    logic [MAX_SET_BITS-1:0] idx;
    logic [TAG_W-1:0]        key;

    assign line_a   = LINE_W'(req_addr >> geom.line_log2);
    assign set_mask = ~({MAX_SET_BITS{1'b1}} << geom.set_bits);
    assign idx      = line_a[MAX_SET_BITS-1:0] & set_mask;
    assign key      = line_a >> geom.set_bits;

    // ---------------- selected set ----------------
    logic [MAX_WAYS-1:0][TAG_W-1:0] cur_tags;
    logic [MAX_WAYS-1:0]            cur_valid;
    logic [MAX_WAYS-1:0]            cur_dirty;
    logic [WAY_W-1:0]               cur_ptr;

    assign cur_tags  = tag_q[req_core][idx];
    assign cur_valid = valid_q[req_core][idx];
    assign cur_dirty = dirty_q[req_core][idx];
    assign cur_ptr   = rr_q[req_core][idx];

    logic [MAX_WAYS-1:0] hit_vec;
    logic                hit;
    logic [WAY_W-1:0]    hit_way;

    tagsim_match #(
        .TAG_W    (TAG_W),
        .MAX_WAYS (MAX_WAYS),
        .WAY_W    (WAY_W)
    ) match_i (
        .valid   (cur_valid),
        .tags    (cur_tags),
        .key     (key),
        .ways    (geom.ways),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    logic [WAY_W-1:0] vic;
    logic [WAY_W-1:0] next_ptr;

    tagsim_victim #(
        .WAY_W (WAY_W)
    ) victim_i (
        .ptr      (cur_ptr),
        .ways     (geom.ways),
        .victim   (vic),
        .next_ptr (next_ptr)
    );

    logic              do_look;
    logic              need_wb;
    logic [LINE_W-1:0] vline;

    assign do_look = req_valid && !flush;
    assign need_wb = !hit && cur_valid[vic] && cur_dirty[vic];
    assign vline   = (cur_tags[vic] << geom.set_bits) | LINE_W'(idx);

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                for (int s = 0; s < NSETS; s++) begin
                    valid_q[c][s] <= '0;
                    dirty_q[c][s] <= '0;
                    rr_q[c][s]    <= '0;
                end
            end
        end else if (req_valid) begin
            if (hit) begin
                if (req_write) dirty_q[req_core][idx][hit_way] <= 1'b1;
            end else begin
                valid_q[req_core][idx][vic] <= 1'b1;
                dirty_q[req_core][idx][vic] <= req_write;
                rr_q[req_core][idx]         <= next_ptr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && do_look && !hit) tag_q[req_core][idx][vic] <= key;
    end

    // ---------------- response ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_miss        <= 1'b0;
            rsp_wb          <= 1'b0;
            rsp_victim_line <= '0;
        end else begin
            rsp_valid       <= do_look;
            rsp_hit         <= do_look && hit;
            rsp_miss        <= do_look && !hit;
            rsp_wb          <= do_look && need_wb;
            rsp_victim_line <= (do_look && need_wb) ? vline : '0;
        end
    end

    // ---------------- assertions ----------------
    // R3: one outcome per response
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    // R3: quiet when no response
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_wb));

    // R8: writeback only accompanies a miss
    p_wb_on_miss_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_wb |-> rsp_miss);

    // R9: a request in the flush cycle is dropped
    p_flush_drop_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rsp_valid);

    // R5: a line is present in at most one way
    p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot0(hit_vec));

    // R7: fills land only in enabled ways
    p_victim_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (FIELD_W'(vic) < geom.ways));

    // R7: hits come only from enabled ways
    p_hit_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit) |-> (FIELD_W'(hit_way) < geom.ways));

endmodule

// File: tb/tagsim_cache_model_tb.sv
module tagsim_cache_model_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_core = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_wb;
    logic [27:0] rsp_victim_line;
    logic [4:0]  geo_line_log2, geo_set_bits, geo_ways;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tagsim_cache_model dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_wr          (cfg_wr),
        .cfg_sel         (cfg_sel),
        .cfg_wdata       (cfg_wdata),
        .flush           (flush),
        .req_valid       (req_valid),
        .req_core        (req_core),
        .req_addr        (req_addr),
        .req_write       (req_write),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_miss        (rsp_miss),
        .rsp_wb          (rsp_wb),
        .rsp_victim_line (rsp_victim_line),
        .geo_line_log2   (geo_line_log2),
        .geo_set_bits    (geo_set_bits),
        .geo_ways        (geo_ways)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Line address at the given stride within set 2 of the default geometry.
    function automatic logic [31:0] sa(input int k);
        return 32'h100 + 32'(k) * 32'h2000;
    endfunction

    // One lookup; response sampled at the negedge after the capturing edge.
    // Packed compare: {valid, hit, miss, wb, victim_line}
    task automatic lk(input string rq, input int core, input logic [31:0] a,
                      input logic w, input logic eh,
                      input logic ewb = 1'b0, input logic [27:0] evl = 28'd0);
        @(negedge clk);
        req_valid = 1'b1;
        req_core  = core[0];
        req_addr  = a;
        req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        check(rq, {rsp_valid, rsp_hit, rsp_miss, rsp_wb, rsp_victim_line},
                  {1'b1, eh, !eh, ewb, evl});
    endtask

    task automatic wcfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 geometry", {geo_line_log2, geo_set_bits, geo_ways}, {5'd7, 5'd6, 5'd4});
        check("R1 response idle", {rsp_valid, rsp_hit, rsp_miss, rsp_wb}, 4'b0000);
        lk("R1 first lookup misses", 0, 32'h0000_0040, 1'b0, 1'b0);
    endtask

    task automatic t_basic();
        do_flush();
        lk("R4 cold miss", 0, 32'h1000, 1'b0, 1'b0);
        lk("R4 same line hit", 0, 32'h107C, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 single-cycle response", {rsp_valid, rsp_hit, rsp_miss}, 3'b000);
        lk("R4 next line misses", 0, 32'h1080, 1'b0, 1'b0);
        lk("R4 first line still hits", 0, 32'h1000, 1'b0, 1'b1);
    endtask

    task automatic t_assoc();
        do_flush();
        for (int k = 0; k < 4; k++) lk("R5 fill set", 0, sa(k), 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) lk("R5 all ways hit", 0, sa(k), 1'b0, 1'b1);
        lk("R6 fifth line evicts way 0", 0, sa(4), 1'b0, 1'b0);
        lk("R6 way0 line gone", 0, sa(0), 1'b0, 1'b0);
        lk("R6 way2 line kept", 0, sa(2), 1'b0, 1'b1);
        lk("R6 way3 line kept", 0, sa(3), 1'b0, 1'b1);
        lk("R6 way1 line evicted", 0, sa(1), 1'b0, 1'b0);
        lk("R6 new line kept", 0, sa(4), 1'b0, 1'b1);
    endtask

    task automatic t_dirty();
        do_flush();
        lk("R8 write miss", 0, sa(0), 1'b1, 1'b0);
        lk("R8 fill", 0, sa(1), 1'b0, 1'b0);
        lk("R8 fill", 0, sa(2), 1'b0, 1'b0);
        lk("R8 fill", 0, sa(3), 1'b0, 1'b0);
        lk("R8 write hit", 0, sa(2), 1'b1, 1'b1);
        lk("R8 dirty victim written back", 0, sa(4), 1'b0, 1'b0, 1'b1, 28'h2);
        lk("R8 clean victim no writeback", 0, sa(5), 1'b0, 1'b0, 1'b0, 28'h0);
        lk("R8 write-hit line written back", 0, sa(6), 1'b0, 1'b0, 1'b1, 28'h82);
    endtask

    task automatic t_ways();
        wcfg(2'd2, 8'd2);
        check("R2 ways programmed", geo_ways, 5'd2);
        do_flush();
        lk("R7 fill", 0, sa(0), 1'b0, 1'b0);
        lk("R7 fill", 0, sa(1), 1'b0, 1'b0);
        lk("R7 hit", 0, sa(0), 1'b0, 1'b1);
        lk("R7 third line evicts way 0", 0, sa(2), 1'b0, 1'b0);
        lk("R7 way0 line gone", 0, sa(0), 1'b0, 1'b0);
        lk("R7 newest kept", 0, sa(2), 1'b0, 1'b1);
        lk("R7 way1 line evicted", 0, sa(1), 1'b0, 1'b0);
        wcfg(2'd2, 8'd4);
    endtask

    task automatic t_clamp();
        wcfg(2'd2, 8'd0);
        check("R2 ways low clamp", geo_ways, 5'd1);
        wcfg(2'd2, 8'd9);
        check("R2 ways high clamp", geo_ways, 5'd4);
        wcfg(2'd0, 8'd2);
        check("R2 line low clamp", geo_line_log2, 5'd4);
        wcfg(2'd0, 8'd200);
        check("R2 line high clamp", geo_line_log2, 5'd7);
        wcfg(2'd1, 8'd15);
        check("R2 sets high clamp", geo_set_bits, 5'd6);
        wcfg(2'd3, 8'd1);
        check("R2 unused select ignored", {geo_line_log2, geo_set_bits, geo_ways},
              {5'd7, 5'd6, 5'd4});
    endtask

    task automatic t_geom();
        wcfg(2'd0, 8'd5);
        wcfg(2'd1, 8'd2);
        do_flush();
        lk("R11 miss line 0", 0, 32'h000, 1'b0, 1'b0);
        lk("R11 32-byte line boundary", 0, 32'h020, 1'b0, 1'b0);
        lk("R11 same 32-byte line", 0, 32'h01F, 1'b0, 1'b1);
        lk("R11 set 0 fill", 0, 32'h080, 1'b1, 1'b0);
        lk("R11 set 0 fill", 0, 32'h100, 1'b0, 1'b0);
        lk("R11 set 0 fill", 0, 32'h180, 1'b0, 1'b0);
        lk("R11 set 1 untouched", 0, 32'h020, 1'b0, 1'b1);
        lk("R11 clean victim", 0, 32'h200, 1'b0, 1'b0, 1'b0, 28'h0);
        lk("R11 dirty victim line", 0, 32'h280, 1'b0, 1'b0, 1'b1, 28'h4);
        wcfg(2'd0, 8'd7);
        wcfg(2'd1, 8'd6);
    endtask

    task automatic t_flush();
        do_flush();
        lk("R9 miss before", 0, 32'h3000, 1'b1, 1'b0);
        lk("R9 hit before", 0, 32'h3000, 1'b0, 1'b1);
        @(negedge clk);
        flush = 1'b1; req_valid = 1'b1; req_core = 1'b0; req_addr = 32'h3000;
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
        check("R9 request during flush dropped", {rsp_valid, rsp_hit, rsp_miss}, 3'b000);
        lk("R9 flushed line misses", 0, 32'h3000, 1'b0, 1'b0);
        lk("R9 fill", 0, sa(1), 1'b0, 1'b0);
        lk("R9 fill", 0, sa(2), 1'b0, 1'b0);
        lk("R9 fill", 0, sa(3), 1'b0, 1'b0);
        lk("R9 dirty cleared by flush", 0, sa(4), 1'b0, 1'b0, 1'b0, 28'h0);
    endtask

    task automatic t_cores();
        do_flush();
        lk("R10 core0 write", 0, sa(0), 1'b1, 1'b0);
        lk("R10 core1 same address misses", 1, sa(0), 1'b0, 1'b0);
        lk("R10 core0 hit", 0, sa(0), 1'b0, 1'b1);
        lk("R10 core1 hit", 1, sa(0), 1'b0, 1'b1);
        for (int k = 1; k < 6; k++) lk("R10 core1 churn", 1, sa(k), 1'b0, 1'b0);
        lk("R10 core0 line survives", 0, sa(0), 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_assoc();
        t_dirty();
        t_ways();
        t_clamp();
        t_geom();
        t_flush();
        t_cores();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule